// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss. It takes a virtual address and picks one of two table base registers. The choice depends on a split value N. It then reads the first-level descriptor through a single-word read port. That descriptor either ends the walk as a 1 MB or 16 MB mapping, or points to a second-level coarse table. In the second case the walker reads that table to resolve a 4 KB or 64 KB page.

The result is presented for one cycle on `done`. It carries either a physical base with size, permission, domain and attribute fields for a TLB refill, or a translation fault tagged with its level. Each of the two address regions has its own disable input. A walk in a disabled region faults at once, without touching memory. Only one walk runs at a time.

Top module: `page_walker`

## Requirements
- R1: With N (`split_n`, 0..7) equal to 0 every address uses base 0. Otherwise an address at or above 2^(32-N) uses base 1 and all lower addresses use base 0.
- R2: The first-level read address is made of two parts. The first is the chosen base with its low bits cleared: 14 bits for base 1, and 14-N bits for base 0. The second is VA[31:20] times 4.
- R3: A request in a region whose disable input (`dis0` for base 0, `dis1` for base 1) is high does not raise `mem_req`. The cycle after the request it gives `done` with `fault`=1 and `fault_lvl`=0.
- R4: First-level bits[1:0] of 00 or 11 end the walk with `fault`=1 and `fault_lvl`=0.
- R5: First-level code 10 finishes the walk after one read.
  - With bit 18 clear the result is a 1 MB section: `pa_base`={d[31:20],0}, `pg_size`=2 and `domain`=d[8:5].
  - With bit 18 set the result is a 16 MB supersection: `pa_base`={d[31:24],0}, `pg_size`=3 and `domain`=0.
  - Both forms return `perm`={d[15],d[11:10]} and `attr`={d[14:12],d[3:2]}.
- R6: First-level code 01 issues a second read at {d[31:10], VA[19:12], 00}. It keeps d[8:5] as the domain.
- R7: For the second-level descriptor, code 00 is a fault with `fault_lvl`=1. The other codes decode as follows:
  - Code 01 is a 64 KB page: `pa_base`={d[31:16],0}, `pg_size`=1 and `attr`={d[14:12],d[3:2]}.
  - Code 1x is a 4 KB page: `pa_base`={d[31:12],0}, `pg_size`=0 and `attr`={d[8:6],d[3:2]}.
  - Both page forms return `perm`={d[9],d[5:4]}.
- R8: `mem_req` stays high with `mem_addr` stable until `mem_rvalid` is seen. A `mem_rvalid` while `mem_req` is low has no effect.
- R9: `done` is high for exactly the cycle after the edge that accepted the final read. `mem_req` is low in that cycle.
- R10: `walk_req` is ignored while a walk's memory read is outstanding.
- R11: During and right after reset, `mem_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_va | input | 32 | Virtual address to translate |
| ttb0 | input | 32 | Table base for the low region |
| ttb1 | input | 32 | Table base for the high region |
| split_n | input | 3 | Region split value N |
| dis0 | input | 1 | Disable walks in the low region |
| dis1 | input | 1 | Disable walks in the high region |
| mem_req | output | 1 | Read request, held until the data returns |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle walk completion |
| fault | output | 1 | Walk ended in a translation fault |
| fault_lvl | output | 1 | Fault level: 0 first, 1 second |
| pa_base | output | 32 | Physical base of the mapping |
| pg_size | output | 2 | 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| perm | output | 3 | Access permission bits |
| domain | output | 4 | Domain number |
| attr | output | 5 | Memory type attributes |

## Verification
The bench targets the region boundary at each N: 0x3FFF_FFFF and 0x4000_0000 with N=2, and the top of memory with N=0. A design that compared against the wrong boundary would read the wrong table or honour the wrong disable bit. The bench also covers read latencies of zero and several cycles, stray read-valid pulses while idle, and `walk_req` held high through a walk. These expose a walker that drops its address early, reacts to unsolicited data, or restarts on a second request. Supersection descriptors and both small-page codes are driven to catch a size decode that ignores bit 18 or the low code bit.

// File: rtl/page_walker.sv
module page_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walk_req,
  input  logic [31:0] walk_va,
  input  logic [31:0] ttb0,
  input  logic [31:0] ttb1,
  input  logic [2:0]  split_n,
  input  logic        dis0,
  input  logic        dis1,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic        fault_lvl,
  output logic [31:0] pa_base,
  output logic [1:0]  pg_size,
  output logic [2:0]  perm,
  output logic [3:0]  domain,
  output logic [4:0]  attr
);
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_t;
  st_t st;
  logic [7:0] mid_q;

  logic [5:0]  hi_shift;
  logic [31:0] hi_bits, lo_mask, l1_addr;
  logic        use_hi, walk_off;

  assign hi_shift = 6'd32 - {3'd0, split_n};
  assign hi_bits  = walk_va >> hi_shift;
  assign use_hi   = (split_n != 3'd0) && (hi_bits != 32'd0);
  assign lo_mask  = 32'hFFFF_FFFF << (5'd14 - {2'd0, split_n});
  assign l1_addr  = use_hi ? ((ttb1 & 32'hFFFF_C000) | {18'd0, walk_va[31:20], 2'b00})
                           : ((ttb0 & lo_mask)       | {18'd0, walk_va[31:20], 2'b00});
  assign walk_off = use_hi ? dis1 : dis0;
  assign mem_req  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mid_q <= '0; mem_addr <= '0;
      done <= 1'b0; fault <= 1'b0; fault_lvl <= 1'b0;
      pa_base <= '0; pg_size <= '0; perm <= '0; domain <= '0; attr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (walk_req) begin
          mid_q <= walk_va[19:12];
          if (walk_off) begin
            done <= 1'b1; fault <= 1'b1; fault_lvl <= 1'b0;
          end else begin
            st <= S_L1; mem_addr <= l1_addr;
          end
        end
        S_L1: if (mem_rvalid) begin
          case (mem_rdata[1:0])
            2'b01: begin
              st       <= S_L2;
              mem_addr <= {mem_rdata[31:10], mid_q, 2'b00};
              domain   <= mem_rdata[8:5];
            end
            2'b10: begin
              st <= S_IDLE; done <= 1'b1; fault <= 1'b0;
              perm <= {mem_rdata[15], mem_rdata[11:10]};
              attr <= {mem_rdata[14:12], mem_rdata[3:2]};
              if (mem_rdata[18]) begin
                pa_base <= {mem_rdata[31:24], 24'd0}; pg_size <= 2'd3; domain <= 4'd0;
              end else begin
                pa_base <= {mem_rdata[31:20], 20'd0}; pg_size <= 2'd2; domain <= mem_rdata[8:5];
              end
            end
            default: begin
              st <= S_IDLE; done <= 1'b1; fault <= 1'b1; fault_lvl <= 1'b0;
            end
          endcase
        end
        S_L2: if (mem_rvalid) begin
          st <= S_IDLE; done <= 1'b1;
          perm <= {mem_rdata[9], mem_rdata[5:4]};
          case (mem_rdata[1:0])
            2'b00: begin fault <= 1'b1; fault_lvl <= 1'b1; end
            2'b01: begin
              fault <= 1'b0; pa_base <= {mem_rdata[31:16], 16'd0}; pg_size <= 2'd1;
              attr <= {mem_rdata[14:12], mem_rdata[3:2]};
            end
            default: begin
              fault <= 1'b0; pa_base <= {mem_rdata[31:12], 12'd0}; pg_size <= 2'd0;
              attr <= {mem_rdata[8:6], mem_rdata[3:2]};
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module page_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_req,
  input logic        dis0,
  input logic        dis1,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        done,
  input logic        fault,
  input logic        fault_lvl
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R8
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R9
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> $past(mem_req && mem_rvalid)); // R9
  AST_L2_FAULT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && fault_lvl |-> $past(mem_req)); // R7
  AST_BOTH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !mem_req && dis0 && dis1 |=> done && fault && !fault_lvl && !mem_req); // R3
endmodule

bind page_walker page_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .dis0(dis0), .dis1(dis1),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .done(done), .fault(fault), .fault_lvl(fault_lvl)
);

// File: tb/sim_page_walker.sv
`timescale 1ns/1ps
module sim_page_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic walk_req = 1'b0, dis0 = 1'b0, dis1 = 1'b0;
  logic [31:0] walk_va = '0, ttb0 = '0, ttb1 = '0, mem_rdata = '0;
  logic [2:0] split_n = '0;
  logic mem_rvalid = 1'b0;
  logic mem_req, done, fault, fault_lvl;
  logic [31:0] mem_addr, pa_base;
  logic [1:0] pg_size;
  logic [2:0] perm;
  logic [3:0] domain;
  logic [4:0] attr;

  page_walker u0 (.clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_va(walk_va),
    .ttb0(ttb0), .ttb1(ttb1), .split_n(split_n), .dis0(dis0), .dis1(dis1),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_lvl(fault_lvl), .pa_base(pa_base), .pg_size(pg_size),
    .perm(perm), .domain(domain), .attr(attr));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  int lat = 0, wcnt = 0;
  bit stray_en = 1'b0;
  longint unsigned resp_q[$];

  // reference model state
  int e_st = 0;
  bit e_done = 0, e_fault = 0, e_lvl = 0;
  longint unsigned e_addr = 0, e_pa = 0, e_size = 0, e_perm = 0, e_dom = 0, e_attr = 0, e_mid = 0;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  function automatic longint unsigned fld(longint unsigned w, int lo, int n);
    return (w >> lo) % (64'd1 << n);
  endfunction

  always @(posedge clk) begin
    longint unsigned w, va, tsz;
    bit hi;
    cycles++;
    if (!rst_n) begin
      e_st = 0; e_done = 0;
    end else begin
      e_done = 0;
      w = mem_rdata;
      if (e_st == 0) begin
        if (walk_req) begin
          va = walk_va;
          hi = (split_n != 0) && (va >= (64'd1 << (32 - split_n)));
          e_mid = fld(va, 12, 8);
          if (hi ? dis1 : dis0) begin
            e_done = 1; e_fault = 1; e_lvl = 0;
          end else begin
            e_st = 1;
            if (hi) e_addr = ttb1 - (ttb1 % 16384) + (va / 1048576) * 4;
            else begin
              tsz = 64'd16384 >> split_n;
              e_addr = ttb0 - (ttb0 % tsz) + (va / 1048576) * 4;
            end
          end
        end
      end else if (e_st == 1) begin
        if (mem_rvalid) begin
          if (fld(w, 0, 2) == 1) begin
            e_st = 2; e_addr = w - (w % 1024) + e_mid * 4; e_dom = fld(w, 5, 4);
          end else if (fld(w, 0, 2) == 2) begin
            e_st = 0; e_done = 1; e_fault = 0;
            e_perm = fld(w, 15, 1) * 4 + fld(w, 10, 2);
            e_attr = fld(w, 12, 3) * 4 + fld(w, 2, 2);
            if (fld(w, 18, 1) == 1) begin
              e_pa = w - (w % (64'd1 << 24)); e_size = 3; e_dom = 0;
            end else begin
              e_pa = w - (w % (64'd1 << 20)); e_size = 2; e_dom = fld(w, 5, 4);
            end
          end else begin
            e_st = 0; e_done = 1; e_fault = 1; e_lvl = 0;
          end
        end
      end else begin
        if (mem_rvalid) begin
          e_st = 0; e_done = 1;
          e_perm = fld(w, 9, 1) * 4 + fld(w, 4, 2);
          if (fld(w, 0, 2) == 0) begin
            e_fault = 1; e_lvl = 1;
          end else if (fld(w, 0, 2) == 1) begin
            e_fault = 0; e_pa = w - (w % 65536); e_size = 1;
            e_attr = fld(w, 12, 3) * 4 + fld(w, 2, 2);
          end else begin
            e_fault = 0; e_pa = w - (w % 4096); e_size = 0;
            e_attr = fld(w, 6, 3) * 4 + fld(w, 2, 2);
          end
        end
      end
    end
    #2;
    if (!rst_n) begin
      chk("R11 mem_req", mem_req, 0);
      chk("R11 done", done, 0);
    end else begin
      chk("R3 R8 mem_req", mem_req, e_st != 0);
      if (e_st == 1) chk("R1 R2 R10 mem_addr", mem_addr, e_addr);
      if (e_st == 2) chk("R6 R10 mem_addr", mem_addr, e_addr);
      chk("R9 R3 done", done, e_done);
      if (e_done) begin
        chk("R4 R7 fault", fault, e_fault);
        if (e_fault) chk("R3 R4 R7 fault_lvl", fault_lvl, e_lvl);
        else begin
          chk("R5 R7 pa_base", pa_base, e_pa);
          chk("R5 R7 pg_size", pg_size, e_size);
          chk("R5 R7 perm", perm, e_perm);
          chk("R5 R6 domain", domain, e_dom);
          chk("R5 R7 attr", attr, e_attr);
        end
      end
    end
  end

  // memory responder with variable latency and stray valid pulses (R8)
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 0; wcnt = 0;
      mem_rdata = $urandom;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_rvalid = 1;
        if (resp_q.size() > 0) mem_rdata = resp_q.pop_front();
        else mem_rdata = $urandom;
      end else wcnt++;
    end else if (stray_en && ($urandom % 6 == 0)) begin
      mem_rvalid = 1; mem_rdata = $urandom;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [2:0] n, input bit d0, input bit d1,
                      input int hold);
    @(negedge clk);
    walk_va = va; split_n = n; dis0 = d0; dis1 = d1; walk_req = 1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      walk_va = $urandom;
    end
    walk_req = 0;
    for (int i = 0; i < 60 && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    ttb0 = 32'h8123_5678; ttb1 = 32'h4567_9ABC;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 section then supersection
    resp_q.push_back(32'hABC0_A5AE); walk(32'h1234_5678, 0, 0, 0, 1);
    resp_q.push_back(32'h7F04_F5F2); walk(32'hFFF0_0000, 0, 0, 1, 1);  // R1 N=0 uses base 0
    // R6 R7 coarse -> large, small (10 and 11), second-level fault
    lat = 2;
    resp_q.push_back(32'h0012_3D61); resp_q.push_back(32'hCAFE_7A35); walk(32'h0056_7000, 3, 0, 0, 4); // R10 hold
    resp_q.push_back(32'h0012_3C01); resp_q.push_back(32'hBEEF_13FE); walk(32'h0001_F000, 3, 0, 0, 1);
    resp_q.push_back(32'h0012_3C01); resp_q.push_back(32'hBEEF_13FF); walk(32'h0001_F000, 3, 0, 0, 1);
    resp_q.push_back(32'h0012_3C01); resp_q.push_back(32'hBEEF_13FC); walk(32'h0001_F000, 3, 0, 0, 1);
    // R4 first-level fault codes 00 and 11
    lat = 0;
    resp_q.push_back(32'hFFFF_FFFC); walk(32'h0800_0000, 1, 0, 0, 1);
    resp_q.push_back(32'hFFFF_FFFF); walk(32'h0800_0000, 1, 0, 0, 1);
    // R1 R3 boundary at N=2
    walk(32'h3FFF_FFFF, 2, 1, 0, 1);
    walk(32'h4000_0000, 2, 1, 0, 1);
    walk(32'h4000_0000, 2, 0, 1, 1);
    walk(32'h3FFF_FFFF, 2, 0, 1, 1);
    walk(32'h8000_0000, 7, 1, 1, 3);
    // random walks, random latency, stray valid pulses
    stray_en = 1;
    for (int k = 0; k < 400; k++) begin
      lat = $urandom % 4;
      ttb0 = $urandom; ttb1 = $urandom;
      if ($urandom % 3 == 0) resp_q.push_back(($urandom & 32'hFFFF_FFFC) | 32'h1);
      walk($urandom, 3'($urandom % 8), ($urandom % 8 == 0), ($urandom % 8 == 0), 1 + $urandom % 3);
    end
    stray_en = 0;
    // R11 reset in the middle of a walk
    lat = 3;
    @(negedge clk); walk_va = 32'h0; split_n = 0; dis0 = 0; walk_req = 1;
    @(negedge clk); walk_req = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; resp_q.delete();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule